// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller

This block is a serial peripheral interface controller for a single byte at a time. A processor reaches it through a small memory-mapped register port. There is a control register, a status register and a data register. When the controller is enabled and set as the bus master, a write to the data register loads the byte and starts the shift. The byte goes out most significant bit first. While it goes out, the byte coming back from the peripheral is shifted in. The serial clock idles low. The output line changes on the falling serial clock edge, and the input line is sampled on the rising edge.

When the eighth bit has been exchanged, a completion flag is set and the received byte is held in a receive buffer. The completion flag can raise an interrupt. A write to the data register during an active exchange does not disturb that exchange; it sets a collision flag instead. The flags are cleared in one of two ways. The first is a two-step access: a status read that sees a flag set, followed by an access to the data register. The second, for the completion flag only, is an interrupt acknowledge.

A slave-select pin, when it is watched as an input, reports a mode fault in master mode. Pulling that pin low also sets the completion flag. The serial clock rate is chosen from four divisors, and a double-speed bit halves the chosen divisor.

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the control register reads 0x00, and the interrupt output and the serial clock are low.
- R2: With enable (control bit 6) and master (control bit 4) set, a data write at address 2 in the idle state starts an exchange. The exchange makes exactly 8 rising serial clock edges. The output line carries the written byte most significant bit first, changing on falling edges. The bits sampled from the input line on rising edges are readable afterwards from address 2, most significant bit first.
- R3: The serial clock period is 4, 16, 64 or 128 system clocks for a rate field (control bits 1:0) of 0, 1, 2 or 3. The period is halved when the double-speed bit (status bit 0) is set. The completion flag (status bit 7) becomes visible exactly 8 serial periods after the clock edge that accepts the data write, and not one cycle earlier.
- R4: A data write during an exchange sets the collision flag (status bit 6). The written byte is discarded, and the exchange finishes with its original transmit byte, received byte and timing.
- R5: The completion and collision flags both clear on the following sequence: a status read (address 1) that observes either flag set, then a read or write of the data register. A data access with no such armed read leaves both flags set, and so does an access to another register after the armed read.
- R6: The interrupt output is high exactly when the completion flag, the interrupt enable (control bit 7) and the global enable input are all set. An acknowledge pulse clears the completion flag.
- R7: When enable, master and the slave-select watch bit (control bit 2) are set, a low level on the slave-select pin sets the completion flag within 3 clock cycles. With the watch bit clear, the pin has no effect.
- R8: Status bits 5 to 1 always read 0, and only status bit 0 is writable. Control bits 5 and 3 read 0. Address 3 reads 0.
- R9: A data write while the controller is disabled, or enabled but not master, starts no exchange: no serial clock edge and no completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 unused |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave-select pin, active low, asynchronous |

## Verification
The divider assertion assumes that the rate field and the double-speed bit stay constant while an exchange is in progress. The stimulus therefore changes them only between exchanges, once the completion flag has been seen. The bus side assumes that read and write strobes never come in the same cycle, and that each strobe addresses one register. Every bus task issues a single one-cycle strobe. The mode-fault checks move the slave-select pin only while the controller is idle. The input line is driven from a bench shift register that advances on falling serial clock edges, so the line is stable at every rising edge where the design samples it.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int DATA_W = 8;
    localparam int HALF_W = 7;
    localparam int DIV_R0 = 4;
    localparam int DIV_R1 = 16;
    localparam int DIV_R2 = 64;
    localparam int DIV_R3 = 128;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       master;
        logic       ss_guard;
        logic [1:0] rate;
    } ctrl_t;

    // Half serial period in system clocks for a rate code and speed bit.
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
        logic [HALF_W-1:0] base;
        unique case (rate)
            2'd0:    base = HALF_W'(DIV_R0 / 2);
            2'd1:    base = HALF_W'(DIV_R1 / 2);
            2'd2:    base = HALF_W'(DIV_R2 / 2);
            default: base = HALF_W'(DIV_R3 / 2);
        endcase
        return dbl ? (base >> 1) : base;
    endfunction

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int HALF_W = spi_byte_pkg::HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_len,
    output logic              tick
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } div_state_t;

    div_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        tick  = run && (cur_q.cnt == (half_len - HALF_W'(1)));
        if (!run || tick) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R3: the half-period counter never passes the selected length
    p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cur_q.cnt < half_len));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = spi_byte_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              samp;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rxbuf;
    } eng_state_t;

    eng_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        done  = 1'b0;
        if (start && !cur_q.busy) begin
            nxt_d.busy    = 1'b1;
            nxt_d.sclk    = 1'b0;
            nxt_d.bit_cnt = '0;
            nxt_d.shreg   = tx_byte;
        end else if (cur_q.busy && tick) begin
            if (!cur_q.sclk) begin
                nxt_d.sclk = 1'b1;
                nxt_d.samp = miso;
            end else begin
                nxt_d.sclk  = 1'b0;
                nxt_d.shreg = {cur_q.shreg[DATA_W-2:0], cur_q.samp};
                if (cur_q.bit_cnt == CNT_W'(DATA_W - 1)) begin
                    nxt_d.busy  = 1'b0;
                    nxt_d.rxbuf = {cur_q.shreg[DATA_W-2:0], cur_q.samp};
                    done        = 1'b1;
                end else begin
                    nxt_d.bit_cnt = cur_q.bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy    = cur_q.busy;
    assign sclk    = cur_q.sclk;
    assign mosi    = cur_q.shreg[DATA_W-1];
    assign rx_byte = cur_q.rxbuf;

    // R1: the serial clock rests low whenever no exchange runs
    p_sclk_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.busy |-> !cur_q.sclk);

    // R2: the output line only moves on a falling serial edge
    p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && !(tick && cur_q.sclk)) |=> $stable(mosi));

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_done,
    input  logic collide,
    input  logic fault,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic irq_ack,
    output logic spif,
    output logic wcol
);

    typedef struct packed {
        logic spif;
        logic wcol;
        logic armed;
    } flag_state_t;

    flag_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (data_acc) begin
            nxt_d.armed = 1'b0;
            if (cur_q.armed) begin
                nxt_d.spif = 1'b0;
                nxt_d.wcol = 1'b0;
            end
        end
        if (stat_rd) begin
            nxt_d.armed = cur_q.spif | cur_q.wcol;
        end
        if (irq_ack) begin
            nxt_d.spif = 1'b0;
        end
        if (xfer_done || fault) begin
            nxt_d.spif = 1'b1;
        end
        if (collide) begin
            nxt_d.wcol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign spif = cur_q.spif;
    assign wcol = cur_q.wcol;

    // R4: a colliding write always leaves the collision flag set
    p_collide_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> wcol);

    // R5: without an armed read, a data access clears nothing
    p_clear_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !cur_q.armed && !irq_ack) |=> (!$fell(spif) && !$fell(wcol)));

    // R3: end of an exchange or a mode fault sets the completion flag
    p_event_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done || fault) |=> spif);

    // R6: an acknowledge with no new event drops the completion flag
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !xfer_done && !fault) |=> !spif);

endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl #(
    parameter int DATA_W      = spi_byte_pkg::DATA_W,
    parameter int HALF_W      = spi_byte_pkg::HALF_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie_i,
    input  logic              irq_ack_i,
    output logic              irq_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              ss_n_i
);
    import spi_byte_pkg::*;

    typedef struct packed {
        ctrl_t                  ctrl;
        logic                   dbl;
        logic [SYNC_STAGES-1:0] ss_sync;
    } top_state_t;

    top_state_t cur_q, nxt_d;

    logic              busy, done, tick, spif, wcol;
    logic              sel_ctrl, sel_stat, sel_data;
    logic              start, collide, fault, data_acc, stat_rd;
    logic [HALF_W-1:0] half_len;
    logic [DATA_W-1:0] rx_byte;
    logic              unused_wdata;

    assign sel_ctrl = (bus_addr == ADDR_CTRL);
    assign sel_stat = (bus_addr == ADDR_STAT);
    assign sel_data = (bus_addr == ADDR_DATA);

    assign start    = bus_wr && sel_data && cur_q.ctrl.enable && cur_q.ctrl.master && !busy;
    assign collide  = bus_wr && sel_data && busy;
    assign data_acc = (bus_wr || bus_rd) && sel_data;
    assign stat_rd  = bus_rd && sel_stat;
    assign fault    = cur_q.ctrl.enable && cur_q.ctrl.master && cur_q.ctrl.ss_guard
                      && !cur_q.ss_sync[SYNC_STAGES-1];
    assign half_len = half_period(cur_q.ctrl.rate, cur_q.dbl);
    assign unused_wdata = ^{bus_wdata[5], bus_wdata[3]};

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.ss_sync = {cur_q.ss_sync[SYNC_STAGES-2:0], ss_n_i};
        if (bus_wr && sel_ctrl) begin
            nxt_d.ctrl.irq_en   = bus_wdata[7];
            nxt_d.ctrl.enable   = bus_wdata[6];
            nxt_d.ctrl.master   = bus_wdata[4];
            nxt_d.ctrl.ss_guard = bus_wdata[2];
            nxt_d.ctrl.rate     = bus_wdata[1:0];
        end
        if (bus_wr && sel_stat) begin
            nxt_d.dbl = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.ss_sync <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {cur_q.ctrl.irq_en, cur_q.ctrl.enable, 1'b0, cur_q.ctrl.master,
                                    1'b0, cur_q.ctrl.ss_guard, cur_q.ctrl.rate};
            ADDR_STAT: bus_rdata = {spif, wcol, 5'b00000, cur_q.dbl};
            ADDR_DATA: bus_rdata = rx_byte;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = spif && cur_q.ctrl.irq_en && gie_i;

    spi_rate_div #(.HALF_W(HALF_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_len (half_len),
        .tick     (tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (bus_wdata),
        .tick    (tick),
        .miso    (miso_i),
        .busy    (busy),
        .sclk    (sclk_o),
        .mosi    (mosi_o),
        .done    (done),
        .rx_byte (rx_byte)
    );

    spi_flag_unit flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_done (done),
        .collide   (collide),
        .fault     (fault),
        .stat_rd   (stat_rd),
        .data_acc  (data_acc),
        .irq_ack   (irq_ack_i),
        .spif      (spif),
        .wcol      (wcol)
    );

    // R9: an exchange begins only when enabled as master
    p_start_needs_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cur_q.ctrl.enable && cur_q.ctrl.master));

endmodule

// File: tb/spi_byte_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_byte_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       gie = 1'b1;
    logic       irq_ack = 1'b0;
    logic       irq, sclk, mosi, miso;
    logic       ss_n = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] slv_tx = 8'h00;
    logic [7:0] slv_rx = 8'h00;
    int         rises = 0;
    int         cyc = 0;
    int         last_rise = 0;
    int         exp_period = 4;
    int         gap_err = 0;

    always #2 clk = ~clk;

    spi_byte_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gie_i     (gie),
        .irq_ack_i (irq_ack),
        .irq_o     (irq),
        .sclk_o    (sclk),
        .mosi_o    (mosi),
        .miso_i    (miso),
        .ss_n_i    (ss_n)
    );

    assign miso = slv_tx[7];

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge sclk) slv_tx <= {slv_tx[6:0], 1'b0};
    always @(posedge sclk) begin
        slv_rx <= {slv_rx[6:0], mosi};
        if (rises > 0 && (cyc - last_rise) != exp_period) gap_err = gap_err + 1;
        last_rise = cyc;
        rises = rises + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    endtask

    task automatic arm_sclk(input logic [7:0] pat, input int period);
        slv_tx = pat; rises = 0; gap_err = 0; exp_period = period;
    endtask

    task automatic full_xfer(input logic [1:0] rate, input logic dbl,
                             input logic [7:0] tx, input logic [7:0] pat);
        logic [7:0] v;
        int d;
        d = (rate == 0) ? 4 : (rate == 1) ? 16 : (rate == 2) ? 64 : 128;
        if (dbl) d = d / 2;
        wr(2'd0, {6'b110100, rate});
        wr(2'd1, {7'd0, dbl});
        arm_sclk(pat, d);
        wr(2'd2, tx);
        repeat (8 * d - 1) @(negedge clk);
        check("R3 flag not yet set", irq, 1'b0);
        @(negedge clk);
        check("R3 flag set on time", irq, 1'b1);
        check("R2 eight serial edges", rises, 8);
        check("R3 serial period", gap_err, 0);
        check("R2 transmitted byte", slv_rx, tx);
        rd(2'd1, v);
        check("R3 status after exchange", v, {7'b1000000, dbl});
        rd(2'd2, v);
        check("R2 received byte", v, pat);
        check("R5 flag cleared by sequence", irq, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq low", irq, 1'b0);
        check("R1 sclk low", sclk, 1'b0);
        rd(2'd1, v); check("R1 status zero", v, 8'h00);
        rd(2'd0, v); check("R1 control zero", v, 8'h00);

        // R8 reserved bits and writable fields
        wr(2'd1, 8'hFF); rd(2'd1, v); check("R8 status writable bit only", v, 8'h01);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R8 control readback", v, 8'hD7);
        rd(2'd3, v); check("R8 unused address", v, 8'h00);

        // R2 R3 sweep over every rate and speed setting
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 2; b++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [7:0] tx, pat;
                    tx  = 8'hA5 ^ 8'(r * 37 + b * 11 + p * 71);
                    pat = {tx[3:0], ~tx[7:4]} ^ 8'(p * 29);
                    full_xfer(2'(r), 1'(b), tx, pat);
                end
            end
        end
        full_xfer(2'd0, 1'b0, 8'h00, 8'hFF);
        full_xfer(2'd0, 1'b1, 8'hFF, 8'h00);

        // R4 collision during an exchange
        wr(2'd0, 8'hD0); wr(2'd1, 8'h00);
        arm_sclk(8'hC3, 4);
        wr(2'd2, 8'h3C);
        repeat (5) @(negedge clk);
        wr(2'd2, 8'hFF);
        wait_irq();
        check("R4 exchange unaffected tx", slv_rx, 8'h3C);
        check("R4 exchange edges", rises, 8);
        rd(2'd1, v); check("R4 collision flag", v, 8'hC0);
        rd(2'd2, v); check("R4 received byte kept", v, 8'hC3);
        rd(2'd1, v); check("R5 both flags cleared", v, 8'h00);

        // R5 no clear without an armed read
        arm_sclk(8'h5A, 4);
        wr(2'd2, 8'h81);
        wait_irq();
        rd(2'd2, v); check("R5 data read value", v, 8'h5A);
        check("R5 unarmed access keeps flag", irq, 1'b1);
        rd(2'd1, v);
        rd(2'd0, v);
        check("R5 other register keeps flag", irq, 1'b1);
        rd(2'd2, v);
        check("R5 armed data read clears", irq, 1'b0);

        // R6 global gate and acknowledge
        gie = 1'b0;
        arm_sclk(8'h11, 4);
        wr(2'd2, 8'h22);
        repeat (40) @(negedge clk);
        check("R6 gated irq", irq, 1'b0);
        rd(2'd1, v); check("R6 flag under gate", v, 8'h80);
        gie = 1'b1;
        #1 check("R6 irq after gate opens", irq, 1'b1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R6 acknowledge clears", irq, 1'b0);
        rd(2'd1, v); check("R6 status after ack", v, 8'h00);

        // R7 mode fault through slave select
        wr(2'd0, 8'hD0);
        @(negedge clk); ss_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 unwatched pin ignored", irq, 1'b0);
        ss_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd0, 8'hD4);
        @(negedge clk); ss_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 fault sets flag", irq, 1'b1);
        ss_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R7 status shows flag", v, 8'h80);
        rd(2'd2, v);
        check("R7 fault flag cleared", irq, 1'b0);

        // R9 no exchange unless enabled as master
        wr(2'd0, 8'h90);
        arm_sclk(8'h00, 4);
        wr(2'd2, 8'h77);
        repeat (40) @(negedge clk);
        check("R9 disabled no edges", rises, 0);
        rd(2'd1, v); check("R9 disabled no flag", v, 8'h00);
        wr(2'd0, 8'hC0);
        wr(2'd2, 8'h77);
        repeat (40) @(negedge clk);
        check("R9 slave no edges", rises, 0);
        rd(2'd1, v); check("R9 slave no flag", v, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule